// File: doc/BRIEF.md
# Cartridge PRG window mapper with cycle-count interrupt

This block sits between a console CPU bus and a cartridge program ROM. The upper half of the CPU address space, from $8000 to $FFFF, always shows the first 32 KiB of the ROM. The 8 KiB window at $6000-$7FFF shows one of two 8 KiB ROM banks. A one-bit register written at $4027 picks which one. On a 32 KiB ROM the bank number is cut to the ROM's width, so the window falls back onto the first two banks.

The block also has a 1-bit timer control at $4068. Once it is enabled, the timer counts CPU cycles and pulls an active-low interrupt line after a fixed number of cycles. A small group of I/O read addresses must return all ones, so the block drives $FF onto the data bus when one of them is read. Registers are captured on the falling edge of the cycle clock `m2`. Address decoding and chip select are combinational.

Top module: `prg_window_mapper`

## Requirements
- R1: A read (`cpu_rw` = 1) at $8000-$FFFF asserts `rom_ce_n` low, and `rom_addr` equals CPU address bits 14:0 zero-extended to the ROM width (8 KiB banks 0 to 3).
- R2: A read at $6000-$7FFF asserts `rom_ce_n` low. `rom_addr` bits 12:0 equal CPU A12:A0, and the bank field above them is 4 when the stored select bit is 0 and 5 when it is 1.
- R3: With a 32 KiB ROM (`PRG_KB` = 32), the bank number for the $6000-$7FFF window is cut to 2 bits, so select bit 0 gives bank 0 and select bit 1 gives bank 1.
- R4: A read anywhere in $4042-$4055 sets `data_oe` to 1 with `data_out` = $FF. Reads of $4041 and $4056 leave `data_oe` at 0.
- R5: Any other access leaves `data_oe` at 0 and `rom_ce_n` at 1. This includes writes (`cpu_rw` = 0) into the ROM windows.
- R6: The select bit is loaded from data bit 0 only by a write to exactly $4027, on the falling edge of `m2`. Reads of $4027, writes to other addresses and data bits 7:1 have no effect on it.
- R7: A write to $4068 with data bit 0 = 1 enables the timer. `irq_n` stays high for 5749 further cycles and goes low on the falling edge that ends the 5750th cycle after the enabling write.
- R8: After the timer reaches 5750 it stops counting, and `irq_n` stays low until the timer is cleared.
- R9: A write to $4068 with data bit 0 = 0 disables the timer, releases `irq_n` high at that edge, and sets the count to zero. A later enable then takes a full 5750 cycles again.
- R10: After reset the select bit is 0 (bank 4), the timer is disabled with a count of zero, and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m2 | input | 1 | CPU cycle clock; registers load on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data_in | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| rom_addr | output | ROM_AW | Program ROM address (log2 of `PRG_KB`*1024 bits) |
| rom_ce_n | output | 1 | Program ROM chip select, active low |
| data_oe | output | 1 | High while the block drives the CPU data bus |
| data_out | output | 8 | Data driven while `data_oe` is high |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A wrong select bit shows on the very next read of the $6000-$7FFF window, as a bank field of 5 instead of 4 (or 1 instead of 0 on a 32 KiB image). The bench reads that window right after every bank write and after every ignored write. A wrong timer count shows only at the interrupt edge, so the bench samples `irq_n` one cycle before and at the expected edge, both on first enable and after a clear. A timer that fails to stop or to clear shows as `irq_n` rising on its own, or not rising when it is written.

// File: rtl/prg_window_pkg.sv
package prg_window_pkg;

    localparam logic [15:0] SEL_REG_ADDR   = 16'h4027;
    localparam logic [15:0] TMR_REG_ADDR   = 16'h4068;
    localparam logic [15:0] ONES_FIRST     = 16'h4042;
    localparam logic [15:0] ONES_LAST      = 16'h4055;
    localparam logic [15:0] LOW_WIN_BASE   = 16'h6000;
    localparam int          BANK_OFS_BITS  = 13;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_SEL  = 2'd1,
        WR_TMR  = 2'd2
    } wr_target_e;

    typedef struct packed {
        logic       rom_hit;
        logic       ones_hit;
        wr_target_e wr_tgt;
    } bus_decode_t;

endpackage

// File: rtl/prg_window_decode.sv
module prg_window_decode
    import prg_window_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rw,
    output bus_decode_t dec
);

    always_comb begin
        dec          = '0;
        dec.rom_hit  = cpu_rw && (cpu_addr >= LOW_WIN_BASE);
        dec.ones_hit = cpu_rw && (cpu_addr >= ONES_FIRST) && (cpu_addr <= ONES_LAST);
        dec.wr_tgt   = WR_NONE;
        if (!cpu_rw) begin
            if (cpu_addr == SEL_REG_ADDR) begin
                dec.wr_tgt = WR_SEL;
            end else if (cpu_addr == TMR_REG_ADDR) begin
                dec.wr_tgt = WR_TMR;
            end
        end
    end

endmodule

// File: rtl/prg_window_romaddr.sv
module prg_window_romaddr
    import prg_window_pkg::*;
#(
    parameter int ROM_AW = 16
) (
    input  logic [15:0]       cpu_addr,
    input  logic              bank_sel,
    output logic [ROM_AW-1:0] rom_addr
);

    localparam int BANK_W = ROM_AW - BANK_OFS_BITS;

    logic [BANK_W-1:0] bank_num;

    always_comb begin
        if (cpu_addr[15]) begin
            bank_num = BANK_W'(cpu_addr[14:13]);
        end else if (cpu_addr[14:13] == 2'b11) begin
            bank_num = BANK_W'({2'b10, bank_sel});
        end else begin
            bank_num = '0;
        end
    end

    assign rom_addr = {bank_num, cpu_addr[BANK_OFS_BITS-1:0]};

endmodule

// File: rtl/prg_window_bank.sv
module prg_window_bank (
    input  logic m2,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic bank_sel
);

    typedef struct packed {
        logic sel;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.sel = wr_bit;
        end
    end

    always_ff @(negedge m2 or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_sel = st_q.sel;

endmodule

// File: rtl/prg_window_irq.sv
module prg_window_irq #(
    parameter int IRQ_LIMIT = 5750,
    parameter int CNT_W     = $clog2(IRQ_LIMIT + 1)
) (
    input  logic             m2,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bit,
    output logic             irq_n,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(IRQ_LIMIT);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(IRQ_LIMIT - 1);

    typedef struct packed {
        logic             en;
        logic             irq;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_bit) begin
            st_d.en  = 1'b0;
            st_d.irq = 1'b0;
            st_d.cnt = '0;
        end else begin
            if (wr_en) begin
                st_d.en = 1'b1;
            end
            if (st_q.en && (st_q.cnt != LIMIT_C)) begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST_C) begin
                    st_d.irq = 1'b1;
                end
            end
        end
    end

    always_ff @(negedge m2 or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = ~st_q.irq;
    assign count = st_q.cnt;

endmodule

// File: rtl/prg_window_mapper.sv
module prg_window_mapper
    import prg_window_pkg::*;
#(
    parameter int PRG_KB    = 64,
    parameter int IRQ_LIMIT = 5750,
    parameter int ROM_AW    = $clog2(PRG_KB * 1024),
    parameter int CNT_W     = $clog2(IRQ_LIMIT + 1)
) (
    input  logic              m2,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data_in,
    input  logic              cpu_rw,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              data_oe,
    output logic [7:0]        data_out,
    output logic              irq_n
);

    bus_decode_t      dec;
    logic             bank_sel;
    logic [CNT_W-1:0] tmr_count;
    logic             data_hi_unused;

    assign data_hi_unused = ^cpu_data_in[7:1];

    prg_window_decode u_decode (
        .cpu_addr (cpu_addr),
        .cpu_rw   (cpu_rw),
        .dec      (dec)
    );

    prg_window_bank u_bank (
        .m2       (m2),
        .rst_n    (rst_n),
        .wr_en    (dec.wr_tgt == WR_SEL),
        .wr_bit   (cpu_data_in[0]),
        .bank_sel (bank_sel)
    );

    prg_window_romaddr #(
        .ROM_AW (ROM_AW)
    ) u_romaddr (
        .cpu_addr (cpu_addr),
        .bank_sel (bank_sel),
        .rom_addr (rom_addr)
    );

    prg_window_irq #(
        .IRQ_LIMIT (IRQ_LIMIT),
        .CNT_W     (CNT_W)
    ) u_irq (
        .m2     (m2),
        .rst_n  (rst_n),
        .wr_en  (dec.wr_tgt == WR_TMR),
        .wr_bit (cpu_data_in[0]),
        .irq_n  (irq_n),
        .count  (tmr_count)
    );

    assign rom_ce_n = ~dec.rom_hit;
    assign data_oe  = dec.ones_hit;
    assign data_out = dec.ones_hit ? 8'hFF : 8'h00;

endmodule

// File: rtl/prg_window_checker.sv
module prg_window_checker #(
    parameter int IRQ_LIMIT = 5750,
    parameter int CNT_W     = 13
) (
    input logic             m2,
    input logic             rst_n,
    input logic [15:0]      cpu_addr,
    input logic [7:0]       cpu_data_in,
    input logic             cpu_rw,
    input logic             rom_ce_n,
    input logic             data_oe,
    input logic [7:0]       data_out,
    input logic             irq_n,
    input logic             bank_sel,
    input logic [CNT_W-1:0] tmr_count
);

    logic sel_wr;
    logic tmr_clr;

    assign sel_wr  = !cpu_rw && (cpu_addr == 16'h4027);
    assign tmr_clr = !cpu_rw && (cpu_addr == 16'h4068) && !cpu_data_in[0];

    a_r9_clear_releases: assert property (@(negedge m2) disable iff (!rst_n)
        tmr_clr |=> (irq_n && (tmr_count == '0)));

    a_r8_irq_sticky: assert property (@(negedge m2) disable iff (!rst_n)
        (!irq_n && !tmr_clr) |=> !irq_n);

    a_r7_irq_at_limit: assert property (@(negedge m2) disable iff (!rst_n)
        !irq_n |-> (tmr_count == CNT_W'(IRQ_LIMIT)));

    a_r8_count_bound: assert property (@(negedge m2) disable iff (!rst_n)
        tmr_count <= CNT_W'(IRQ_LIMIT));

    a_r6_sel_hold: assert property (@(negedge m2) disable iff (!rst_n)
        !sel_wr |=> $stable(bank_sel));

    a_r6_sel_load: assert property (@(negedge m2) disable iff (!rst_n)
        sel_wr |=> (bank_sel == $past(cpu_data_in[0])));

    a_r4_ones_value: assert property (@(negedge m2) disable iff (!rst_n)
        data_oe |-> (data_out == 8'hFF));

    a_r5_no_contention: assert property (@(negedge m2) disable iff (!rst_n)
        !(data_oe && !rom_ce_n));

endmodule

bind prg_window_mapper prg_window_checker #(
    .IRQ_LIMIT (IRQ_LIMIT),
    .CNT_W     (CNT_W)
) u_chk (
    .m2          (m2),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_data_in (cpu_data_in),
    .cpu_rw      (cpu_rw),
    .rom_ce_n    (rom_ce_n),
    .data_oe     (data_oe),
    .data_out    (data_out),
    .irq_n       (irq_n),
    .bank_sel    (bank_sel),
    .tmr_count   (tmr_count)
);

// File: tb/prg_window_mapper_test.sv
module prg_window_mapper_test;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 5750;

    logic        m2 = 1'b1;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data_in = 8'h00;
    logic        cpu_rw = 1'b1;
    logic [15:0] rom_addr;
    logic        rom_ce_n, data_oe, irq_n;
    logic [7:0]  data_out;
    logic [14:0] rom_addr32;
    logic        rom_ce_n32, data_oe32, irq_n32;
    logic [7:0]  data_out32;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;
    logic exp_sel = 1'b0;
    logic exp_irq_n = 1'b1;

    always #(CLK_PERIOD/2) m2 = ~m2;

    prg_window_mapper #(.PRG_KB(64)) uut (
        .m2(m2), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data_in(cpu_data_in),
        .cpu_rw(cpu_rw), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
        .data_oe(data_oe), .data_out(data_out), .irq_n(irq_n)
    );

    prg_window_mapper #(.PRG_KB(32)) uut32 (
        .m2(m2), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data_in(cpu_data_in),
        .cpu_rw(cpu_rw), .rom_addr(rom_addr32), .rom_ce_n(rom_ce_n32),
        .data_oe(data_oe32), .data_out(data_out32), .irq_n(irq_n32)
    );

    function automatic logic [31:0] exp_rom(input logic [15:0] a, input logic s, input int aw);
        logic [31:0] full;
        if (a[15]) full = {17'd0, a[14:0]};
        else       full = ((32'd4 + {31'd0, s}) << 13) | {19'd0, a[12:0]};
        return full & ((32'd1 << aw) - 32'd1);
    endfunction

    function automatic logic exp_ce_n(input logic [15:0] a, input logic rw);
        return !(rw && (a >= 16'h6000));
    endfunction

    function automatic logic exp_oe(input logic [15:0] a, input logic rw);
        return rw && (a >= 16'h4042) && (a <= 16'h4055);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rw);
        @(posedge m2);
        #1;
        cpu_addr = a;
        cpu_data_in = d;
        cpu_rw = rw;
        @(negedge m2);
        #1;
    endtask

    task automatic check_bus(input string req);
        logic ce, oe;
        ce = exp_ce_n(cpu_addr, cpu_rw);
        oe = exp_oe(cpu_addr, cpu_rw);
        check(rom_ce_n == ce && rom_ce_n32 == ce, req, {30'd0, rom_ce_n, rom_ce_n32}, {30'd0, ce, ce});
        check(data_oe == oe && data_oe32 == oe, req, {30'd0, data_oe, data_oe32}, {30'd0, oe, oe});
        if (oe) check(data_out == 8'hFF && data_out32 == 8'hFF, req, {16'd0, data_out, data_out32}, 32'hFFFF);
        if (!ce) begin
            check({16'd0, rom_addr} == exp_rom(cpu_addr, exp_sel, 16), req,
                  {16'd0, rom_addr}, exp_rom(cpu_addr, exp_sel, 16));
            check({17'd0, rom_addr32} == exp_rom(cpu_addr, exp_sel, 15), req,
                  {17'd0, rom_addr32}, exp_rom(cpu_addr, exp_sel, 15));
        end
    endtask

    task automatic check_irq(input string req, input logic e);
        check(irq_n == e && irq_n32 == e, req, {30'd0, irq_n, irq_n32}, {30'd0, e, e});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(16'h0000, 8'h00, 1'b1);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        #(CLK_PERIOD * 3 + 1);
        rst_n = 1'b1;

        // R10: reset state, window shows bank 4 (bank 0 on 32 KiB)
        check_irq("R10", 1'b1);
        bus(16'h6000, 8'h00, 1'b1);
        check_bus("R10");
        check(rom_addr == 16'h8000, "R10", {16'd0, rom_addr}, 32'h8000);

        // R1: upper window, bank ends
        bus(16'h8000, 8'h00, 1'b1); check_bus("R1");
        bus(16'hFFFF, 8'h00, 1'b1); check_bus("R1");
        bus(16'hC123, 8'h00, 1'b1); check_bus("R1");

        // R6 / R2 / R3: select load uses only bit 0
        bus(16'h4027, 8'h01, 1'b0); exp_sel = 1'b1;
        bus(16'h7ABC, 8'h00, 1'b1); check_bus("R2");
        check(rom_addr32 == 15'h3ABC, "R3", {17'd0, rom_addr32}, 32'h3ABC);
        bus(16'h4127, 8'h00, 1'b0);
        bus(16'h6001, 8'h00, 1'b1); check_bus("R6");
        bus(16'h4027, 8'h00, 1'b1);
        bus(16'h6002, 8'h00, 1'b1); check_bus("R6");
        bus(16'h4027, 8'hFE, 1'b0); exp_sel = 1'b0;
        bus(16'h7FFF, 8'h00, 1'b1); check_bus("R6");
        check(rom_addr == 16'h9FFF, "R2", {16'd0, rom_addr}, 32'h9FFF);

        // R4: ones block edges
        bus(16'h4041, 8'h00, 1'b1); check_bus("R4");
        bus(16'h4042, 8'h00, 1'b1); check_bus("R4");
        bus(16'h4055, 8'h00, 1'b1); check_bus("R4");
        bus(16'h4056, 8'h00, 1'b1); check_bus("R4");
        bus(16'h4050, 8'h00, 1'b0); check_bus("R4");

        // R5: writes into ROM windows and other reads drive nothing
        bus(16'h8000, 8'h55, 1'b0); check_bus("R5");
        bus(16'h6000, 8'h55, 1'b0); check_bus("R5");
        bus(16'h5FFF, 8'h00, 1'b1); check_bus("R5");

        // Constrained random mix, timer left disabled
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            logic        rw;
            int          kind;
            kind = int'($urandom % 7);
            d  = 8'($urandom);
            rw = 1'($urandom);
            a  = 16'($urandom);
            case (kind)
                0: begin a = 16'h4027; rw = 1'b0; end
                1: a = 16'h4040 + 16'($urandom % 24);
                2: a = 16'h6000 + 16'($urandom % 16'h2000);
                3: a = 16'h8000 + 16'($urandom % 16'h8000);
                4: begin a = 16'h4068; d[0] = 1'b0; end
                default: ;
            endcase
            if (a == 16'h4068) d[0] = 1'b0;
            bus(a, d, rw);
            check_bus("R5");
            check_irq("R9", 1'b1);
            if (!rw && a == 16'h4027) exp_sel = d[0];
        end

        // R7: exact fire cycle
        bus(16'h4068, 8'h01, 1'b0);
        idle(LIMIT - 1);
        check_irq("R7", 1'b1);
        idle(1);
        check_irq("R7", 1'b0);

        // R8: holds, other writes do not release
        bus(16'h4027, 8'h00, 1'b0);
        bus(16'h4068, 8'h01, 1'b0);
        idle(100);
        check_irq("R8", 1'b0);

        // R9: clear with bit0=0 (other bits set), then full period again
        bus(16'h4068, 8'hFE, 1'b0);
        check_irq("R9", 1'b1);
        idle(50);
        check_irq("R9", 1'b1);
        bus(16'h4068, 8'h01, 1'b0);
        idle(LIMIT - 1);
        check_irq("R9", 1'b1);
        idle(1);
        check_irq("R9", 1'b0);
        bus(16'h4068, 8'h00, 1'b0);
        check_irq("R9", 1'b1);

        done = 1;
        summary();
        $finish;
    end

endmodule